// File: doc/BRIEF.md
# Daisy-Chain Byte Receiver and Repeater

This block sits on one port of a stacked-device serial chain. It takes an oversampled line signal in which every bit is sent as a couplet of two complementary half-bits. It locks its timing to the rising edge of a leading high half-bit, the lead-in. It checks that two sync couplets of value 0 follow. It then decodes a start-of-frame flag, eight data bits with the least significant bit first, and a byte-error flag. A single high half-bit, the tail, closes the byte. Each decoded element is rebuilt and driven out to the next device exactly one couplet after it arrived, so the byte moves up the chain while it is still being received.

A byte goes to the local command side, as a one-cycle strobe with its data and start flag, only when every couplet decoded cleanly and the incoming error flag was clear. A couplet that cannot be decoded goes out as a 0, and the outgoing byte-error flag is forced high. A byte that already carries the error flag keeps it on the way out, and the block records that such a byte was seen. Two sticky status flags, one for local protocol errors and one for received error-tagged bytes, stay set until a write-one-to-clear strobe clears them.

Line encoding: a high half followed by a low half is a 1. A low half followed by a high half is a 0. Two equal halves cannot be decoded. The idle line is low. Bytes are separated by at least one couplet of idle line.

Top module: `chain_byte_repeater`

## Requirements
- R1: A byte starts on a low-to-high change of `rx_in` while the receiver is idle. If the first half-bit then votes low, the receiver goes back to idle without setting any flag and without driving `tx_out`.
- R2: Each half-bit takes the value that more than half of its OS samples carry (with OS=4, three or four high samples mean high). A single corrupted sample in a half therefore changes nothing.
- R3: Both sync couplets must decode as 0. If either one does not, `perr_flag` is set, nothing is delivered, and `tx_out` stays low from the cycle after that couplet's last sample.
- R4: The data bits arrive D0 first and D7 last, after the start couplet. When a byte completes cleanly with incoming error flag 0, `rx_valid` is high for exactly one cycle, the cycle after the tail's last sample, and `rx_data` and `rx_sof` hold the byte at that time.
- R5: An undecodable start or data couplet goes out as 0 and the outgoing error couplet is 1. `perr_flag` is set and the byte is not delivered.
- R6: A byte whose incoming error couplet decodes as 1 goes out with error 1. `tag_flag` is set and the byte is not delivered.
- R7: After the error couplet, the receiver waits up to four half-bits (two couplets) for a high half. A tail in the fourth half is still accepted. If no high half arrives, the byte is dropped and `perr_flag` is set.
- R8: `tx_out` is the rebuilt byte delayed by exactly 2*OS clock cycles: the lead-in, sync 0s, start and data bits, the error flag and a one-half tail, with the line low everywhere else.
- R9: `perr_flag` and `tag_flag` stay set until a cycle in which `status_clr[0]` or `status_clr[1]`, respectively, is high. A set in the same cycle takes priority over the clear.
- R10: While and after reset, `tx_out`, `rx_valid`, `perr_flag` and `tag_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, OS cycles per half-bit |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_in | input | 1 | Oversampled incoming line level |
| status_clr | input | 2 | Write-one-to-clear: bit 0 clears perr_flag, bit 1 clears tag_flag |
| tx_out | output | 1 | Rebuilt line level toward the next device |
| rx_valid | output | 1 | One-cycle strobe for a cleanly received byte |
| rx_data | output | 8 | Received data byte |
| rx_sof | output | 1 | Received start-of-frame flag |
| perr_flag | output | 1 | Sticky local protocol or decode error |
| tag_flag | output | 1 | Sticky flag for a byte received with error flag set |

## Verification
The hardest case to reach from the ports is one where the outgoing stream and the local result disagree. Examples are an undecodable D7, which must still be forwarded at full length with the error flag forced, and a missing tail, which must still be regenerated on `tx_out` while the byte is dropped locally. The bench builds each byte from half-bit lists with a separate expected forwarded list. It compares `tx_out` sample by sample against that list shifted by two half-bits, across corrupted couplets, error-tagged bytes, a late tail in the last allowed half, and a sync abort where the input itself stops.

// File: rtl/chain_byte_repeater.sv
module chain_byte_repeater #(
  parameter int OS        = 4,
  parameter int POST_WAIT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_in,
  input  logic [1:0] status_clr,
  output logic       tx_out,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       rx_sof,
  output logic       perr_flag,
  output logic       tag_flag
);
  localparam int SW = $clog2(OS);
  localparam int OW = $clog2(OS + 1);
  localparam int CW = $clog2(2 * OS);
  localparam int PW = $clog2(POST_WAIT + 1);
  localparam logic [SW-1:0] HALF_LAST = SW'(OS - 1);
  localparam logic [OW-1:0] VOTE_THR  = OW'(OS / 2);
  localparam logic [CW-1:0] TX_MID    = CW'(OS);
  localparam logic [CW-1:0] TX_LAST   = CW'(2 * OS - 1);
  localparam logic [PW-1:0] POST_LAST = PW'(POST_WAIT - 1);
  localparam logic [3:0]    E_SOF     = 4'd2;
  localparam logic [3:0]    E_FLAG    = 4'd11;

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_BITS, S_TAIL} st_t;

  st_t           st;
  logic [SW-1:0] samp;
  logic [OW-1:0] ones, vote;
  logic          half, h0, rx_q, err, inb;
  logic [3:0]    elem;
  logic [PW-1:0] pcnt;
  logic [7:0]    dat;
  logic          sof_r;
  logic          tx_on, tx_a, tx_b, tx_post;
  logic [CW-1:0] tx_cnt;

  logic half_end, hv, bit_ok, bit_v, flag_out;
  logic ld, ld_a, ld_b, ld_post, kill, perr_set, tag_set;

  assign vote     = ones + OW'(rx_in);
  assign half_end = (st != S_IDLE) && (samp == HALF_LAST);
  assign hv       = vote > VOTE_THR;
  assign bit_ok   = h0 ^ hv;
  assign bit_v    = h0 & bit_ok;
  assign flag_out = err | ~bit_ok | bit_v;

  always_comb begin
    ld = 1'b0; ld_a = 1'b0; ld_b = 1'b0; ld_post = 1'b0; kill = 1'b0;
    if (half_end) begin
      if (st == S_LEAD && hv) begin
        ld = 1'b1; ld_b = 1'b1;
      end else if (st == S_BITS && half) begin
        if (elem < E_SOF) begin
          if (bit_ok && !bit_v) begin ld = 1'b1; ld_b = 1'b1; end
          else kill = 1'b1;
        end else if (elem == E_FLAG) begin
          ld = 1'b1; ld_a = flag_out; ld_b = ~flag_out; ld_post = 1'b1;
        end else begin
          ld = 1'b1; ld_a = bit_v; ld_b = ~bit_v;
        end
      end
    end
  end

  assign tag_set  = half_end && st == S_BITS && half && elem == E_FLAG && bit_v;
  assign perr_set = kill
                  | (half_end && st == S_BITS && half && elem == E_FLAG && (err | ~bit_ok))
                  | (half_end && st == S_TAIL && !hv && pcnt == POST_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; samp <= '0; ones <= '0; half <= 1'b0; h0 <= 1'b0;
      rx_q <= 1'b0; err <= 1'b0; inb <= 1'b0; elem <= '0; pcnt <= '0;
      dat <= '0; sof_r <= 1'b0; rx_valid <= 1'b0;
    end else begin
      rx_q     <= rx_in;
      rx_valid <= 1'b0;
      if (st == S_IDLE) begin
        if (rx_in && !rx_q) begin
          st <= S_LEAD; samp <= SW'(1); ones <= OW'(1);
        end
      end else begin
        if (half_end) begin samp <= '0; ones <= '0; end
        else begin samp <= samp + SW'(1); ones <= vote; end
      end
      if (half_end) begin
        case (st)
          S_LEAD: begin
            if (hv) begin
              st <= S_BITS; half <= 1'b0; elem <= '0; err <= 1'b0; inb <= 1'b0;
            end else st <= S_IDLE;
          end
          S_BITS: begin
            if (!half) begin
              h0 <= hv; half <= 1'b1;
            end else begin
              half <= 1'b0;
              elem <= elem + 4'd1;
              if (elem < E_SOF) begin
                if (kill) st <= S_IDLE;
              end else if (elem == E_FLAG) begin
                inb <= bit_v; err <= err | ~bit_ok; st <= S_TAIL; pcnt <= '0;
              end else if (elem == E_SOF) begin
                sof_r <= bit_v; err <= err | ~bit_ok;
              end else begin
                dat <= {bit_v, dat[7:1]}; err <= err | ~bit_ok;
              end
            end
          end
          S_TAIL: begin
            if (hv) begin
              st <= S_IDLE; rx_valid <= ~err & ~inb;
            end else if (pcnt == POST_LAST) st <= S_IDLE;
            else pcnt <= pcnt + PW'(1);
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      perr_flag <= 1'b0; tag_flag <= 1'b0;
    end else begin
      perr_flag <= perr_set | (perr_flag & ~status_clr[0]);
      tag_flag  <= tag_set  | (tag_flag  & ~status_clr[1]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_on <= 1'b0; tx_a <= 1'b0; tx_b <= 1'b0; tx_cnt <= '0; tx_post <= 1'b0;
    end else if (kill) begin
      tx_on <= 1'b0; tx_post <= 1'b0;
    end else if (ld) begin
      tx_on <= 1'b1; tx_a <= ld_a; tx_b <= ld_b; tx_cnt <= '0; tx_post <= ld_post;
    end else if (tx_on) begin
      if (tx_cnt == TX_LAST) begin
        if (tx_post) begin
          tx_a <= 1'b1; tx_b <= 1'b0; tx_cnt <= '0; tx_post <= 1'b0;
        end else tx_on <= 1'b0;
      end else tx_cnt <= tx_cnt + CW'(1);
    end
  end

  assign tx_out  = tx_on & ((tx_cnt < TX_MID) ? tx_a : tx_b);
  assign rx_data = dat;
  assign rx_sof  = sof_r;

  assert_sync_abort_R3: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !tx_out);
  assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  assert_flag_forwarded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tag_set |=> tx_out);
  assert_tagged_not_delivered_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !inb);
  assert_perr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_flag && !status_clr[0]) |=> perr_flag);
  assert_tag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_flag && !status_clr[1]) |=> tag_flag);
endmodule

// File: tb/chain_byte_repeater_tb_top.sv
module chain_byte_repeater_tb_top;
  localparam int OS   = 4;
  localparam int MAXS = 256;

  typedef struct packed {
    logic       sof;
    logic [7:0] d;
    logic       flag;
    logic [3:0] bad;
    logic       noise;
    logic       ev;
    logic       ep;
    logic       et;
  } vec_t;

  localparam vec_t VT [0:5] = '{
    {1'b1, 8'hA5, 1'b0, 4'hF, 1'b0, 1'b1, 1'b0, 1'b0},
    {1'b0, 8'h3C, 1'b0, 4'hF, 1'b1, 1'b1, 1'b0, 1'b0},
    {1'b0, 8'h80, 1'b0, 4'h8, 1'b0, 1'b0, 1'b1, 1'b0},
    {1'b1, 8'h01, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 1'b0},
    {1'b0, 8'hFF, 1'b1, 4'hF, 1'b0, 1'b0, 1'b0, 1'b1},
    {1'b0, 8'h00, 1'b1, 4'h4, 1'b1, 1'b0, 1'b1, 1'b1}
  };

  logic       clk = 1'b0, rst_n = 1'b0, rx_in = 1'b0;
  logic [1:0] status_clr = 2'b00;
  logic       tx_out, rx_valid, rx_sof, perr_flag, tag_flag;
  logic [7:0] rx_data;

  always #5 clk = ~clk;

  chain_byte_repeater #(.OS(OS), .POST_WAIT(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .status_clr(status_clr),
    .tx_out(tx_out), .rx_valid(rx_valid), .rx_data(rx_data), .rx_sof(rx_sof),
    .perr_flag(perr_flag), .tag_flag(tag_flag));

  int   errs = 0, checks = 0;
  logic ins [0:MAXS-1];
  logic exs [0:MAXS-1];
  logic ih  [0:63];
  logic eh  [0:63];
  int   nsamp, nh, ne, vcount, txbad;
  logic [7:0] cap_d;
  logic cap_s;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put(input logic i, input logic e);
    ih[nh] = i; eh[nh] = e; nh++;
  endtask

  task automatic build(input logic sof, input logic [7:0] d, input logic flag,
                       input int bad, input int syncmode, input int pd, input logic noise);
    logic v, bo;
    nh = 0;
    put(1'b1, 1'b1);
    if (syncmode == 1) begin
      put(1'b1, 1'b0); put(1'b0, 1'b1); ne = 1;
    end else begin
      put(1'b0, 1'b0); put(1'b1, 1'b1);
      if (syncmode == 2) begin
        put(1'b1, 1'b0); put(1'b1, 1'b1); ne = 3;
      end else begin
        put(1'b0, 1'b0); put(1'b1, 1'b1);
        for (int k = 0; k < 9; k++) begin
          v = (k == 0) ? sof : d[k-1];
          if (bad == k) begin put(1'b1, 1'b0); put(1'b1, 1'b1); end
          else begin put(v, v); put(!v, !v); end
        end
        bo = flag | (bad >= 0);
        put(flag, bo); put(!flag, !bo);
        if (pd < 0) put(1'b0, 1'b1);
        else for (int k = 0; k <= pd; k++) put(k == pd, k == 0);
        ne = nh;
      end
    end
    nsamp = nh * OS;
    for (int s = 0; s < nsamp; s++) begin
      ins[s] = ih[s/OS] ^ (noise && (s % OS == 1));
      exs[s] = (s / OS < ne) ? eh[s/OS] : 1'b0;
    end
  endtask

  task automatic play();
    logic e;
    vcount = 0; txbad = 0;
    for (int j = 0; j < nsamp + 8 * OS; j++) begin
      @(negedge clk);
      e = (j >= 2 * OS && j - 2 * OS < nsamp) ? exs[j - 2 * OS] : 1'b0;
      if (tx_out !== e) txbad++;
      if (rx_valid) begin vcount++; cap_d = rx_data; cap_s = rx_sof; end
      rx_in = (j < nsamp) ? ins[j] : 1'b0;
    end
  endtask

  task automatic clear_flags(input logic [1:0] m);
    @(negedge clk); status_clr = m;
    @(negedge clk); status_clr = 2'b00;
  endtask

  initial begin
    #2_000_000;
    errs++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 tx_out in reset", tx_out, 0);
    chk("R10 rx_valid in reset", rx_valid, 0);
    chk("R10 flags in reset", {perr_flag, tag_flag}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 flags after reset", {perr_flag, tag_flag, tx_out}, 0);

    for (int i = 0; i < 6; i++) begin
      clear_flags(2'b11);
      build(VT[i].sof, VT[i].d, VT[i].flag,
            (VT[i].bad == 4'hF) ? -1 : int'(VT[i].bad), 0, 0, VT[i].noise);
      play();
      chk("R4/R5/R6 delivery count", vcount, {31'd0, VT[i].ev});
      if (VT[i].ev) begin
        chk("R4 data LSB first (R2 noise)", cap_d, VT[i].d);
        chk("R4 sof", cap_s, VT[i].sof);
      end
      chk("R5 perr", perr_flag, VT[i].ep);
      chk("R6 tag", tag_flag, VT[i].et);
      chk("R8 forwarded stream", txbad, 0);
    end

    clear_flags(2'b11);
    nsamp = OS;
    for (int s = 0; s < OS; s++) begin ins[s] = (s == 0); exs[s] = 1'b0; end
    play();
    chk("R1 glitch no delivery", vcount, 0);
    chk("R1 glitch no flag", {perr_flag, tag_flag}, 0);
    chk("R1 glitch tx idle", txbad, 0);

    clear_flags(2'b11);
    build(1'b0, 8'h55, 1'b0, -1, 1, 0, 1'b0);
    play();
    chk("R3 sync0 value 1 perr", perr_flag, 1);
    chk("R3 sync0 no delivery", vcount, 0);
    chk("R3 sync0 tx stops", txbad, 0);

    clear_flags(2'b11);
    build(1'b0, 8'h55, 1'b0, -1, 2, 0, 1'b0);
    play();
    chk("R3 sync1 undecodable perr", perr_flag, 1);
    chk("R3 sync1 tx stops", txbad, 0);

    clear_flags(2'b11);
    build(1'b1, 8'h96, 1'b0, -1, 0, 3, 1'b0);
    play();
    chk("R7 late tail delivered", vcount, 1);
    chk("R7 late tail data", cap_d, 8'h96);
    chk("R7 late tail no perr", perr_flag, 0);

    clear_flags(2'b11);
    build(1'b0, 8'h5A, 1'b0, -1, 0, -1, 1'b0);
    play();
    chk("R7 timeout perr", perr_flag, 1);
    chk("R7 timeout no delivery", vcount, 0);
    chk("R8 tail regenerated on timeout", txbad, 0);

    build(1'b0, 8'h11, 1'b0, -1, 0, 0, 1'b0);
    play();
    chk("R9 perr sticky over clean byte", perr_flag, 1);
    chk("R4 clean byte after error", cap_d, 8'h11);
    build(1'b0, 8'h22, 1'b1, -1, 0, 0, 1'b0);
    play();
    chk("R9 tag set", tag_flag, 1);
    clear_flags(2'b01);
    chk("R9 clear bit0 clears perr", perr_flag, 0);
    chk("R9 clear bit0 keeps tag", tag_flag, 1);
    clear_flags(2'b10);
    chk("R9 clear bit1 clears tag", tag_flag, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule